// File: doc/BRIEF.md
# Compressed Field Size Limiter

This block enforces a per-field budget on the output of a compressing video encoder. It counts the 32-bit words that the encoder emits for each field and compares the running count against a programmable ceiling. Once the ceiling is reached, every quantized sample that still arrives in that field leaves the block as zero. The downstream coder then spends almost no bits on the rest of the field. The stream does not stop, and the field boundary structure stays intact.

The ceiling comes from a max-count register that holds the upper bits of a wider word count. The lowest four bits of the ceiling are always zero, so the budget can only be set in steps of 16 words. Limiting works only while an enable bit in a separate mode register is set. A field-start pulse opens each new field and clears both the count and the limit flag. Samples leave the block through one register stage.

Top module: `field_size_limiter`

## Requirements
- R1: After reset, `limitHit` is 0, `sampleOutValid` is 0 and `sampleOut` is 0.
- R2: The limit in words is `maxCount` shifted left by 4, with the four low bits zero. Each cycle with `wordStrobe` high adds one word. `limitHit` goes high in the cycle after the strobe that brings the count to the limit or above.
- R3: Limiting is enabled by bit 4 of `modeReg`. No other bit of `modeReg` has any effect on the outputs.
- R4: When `modeReg[4]` is 0 in a cycle, `limitHit` is 0 in the following cycle. Samples then pass through unchanged.
- R5: A sample accepted in a cycle where `limitHit` is 1 and `fieldStart` is 0 is output as zero.
- R6: `fieldStart` clears the word count. A `wordStrobe` in the same cycle counts as the first word of the new field. A sample accepted in the `fieldStart` cycle belongs to the new field and passes unchanged.
- R7: While enable and `maxCount` stay constant, `limitHit` stays 1 once set, until the next `fieldStart`.
- R8: `sampleOutValid` follows `sampleValid` one cycle later. `sampleOut` then carries the gated sample and otherwise holds its value.
- R9: With `maxCount` = 0, `limitHit` is 1 from the cycle after `fieldStart` onward, so every later sample of that field is zeroed.
- R10: The word count saturates at its all-ones value and never wraps, so `limitHit` stays high however many words a field produces.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fieldStart | input | 1 | Pulse marking the first cycle of a new field |
| wordStrobe | input | 1 | One 32-bit compressed word emitted this cycle |
| sampleValid | input | 1 | Quantized sample present on `sampleIn` |
| sampleIn | input | SAMPLE_W | Quantized sample |
| modeReg | input | MODE_W | Mode register; bit 4 enables limiting |
| maxCount | input | MAX_W | Upper bits of the word-count limit |
| sampleOut | output | SAMPLE_W | Gated sample, registered |
| sampleOutValid | output | 1 | `sampleOut` updated this cycle |
| limitHit | output | 1 | Word budget of current field reached |

## Verification
Two pairs of events can fall in the same cycle. The first is a field start together with a word strobe and a sample. The second is the strobe that reaches the limit together with a sample. Directed cases produce both pairs with small limits of 0 and 32 words. The random fields then give them freely, because the start, word and sample strobes are drawn independently each cycle. Each output sample is compared with a bench model of the requirements. That model treats a sample in the start cycle as unzeroed, and a sample in the limit-reaching cycle as still allowed through.

// File: rtl/fsl_pkg.sv
package fsl_pkg;
  typedef struct packed {
    logic take;
    logic zeroSample;
  } gateCtl_t;
endpackage

// File: rtl/fsl_limit_ctrl.sv
module fsl_limit_ctrl
  import fsl_pkg::*;
#(
  parameter int MAX_W      = 16,
  parameter int STEP_BITS  = 4,
  parameter int MODE_W     = 8,
  parameter int ENABLE_BIT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fieldStart,
  input  logic              wordStrobe,
  input  logic              sampleValid,
  input  logic [MODE_W-1:0] modeReg,
  input  logic [MAX_W-1:0]  maxCount,
  output gateCtl_t          gateCtl,
  output logic              limitHit
);
  localparam int CNT_W = MAX_W + STEP_BITS;
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] wordCount;
  logic [CNT_W-1:0] nextCount;
  logic [CNT_W-1:0] limitWords;
  logic             limitEn;

  assign limitWords = {maxCount, {STEP_BITS{1'b0}}};
  assign limitEn    = modeReg[ENABLE_BIT];

  always_comb begin
    nextCount = wordCount;
    if (fieldStart) begin
      nextCount = wordStrobe ? CNT_W'(1) : '0;
    end else if (wordStrobe && (wordCount != CNT_TOP)) begin
      nextCount = wordCount + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordCount <= '0;
      limitHit  <= 1'b0;
    end else begin
      wordCount <= nextCount;
      limitHit  <= limitEn && (nextCount >= limitWords);
    end
  end

  assign gateCtl.take       = sampleValid;
  assign gateCtl.zeroSample = limitHit && !fieldStart;

  // R6: field start leaves at most one word counted
  a_r6_clear: assert property (@(posedge clk) disable iff (!rstN)
    fieldStart |=> (wordCount <= CNT_W'(1)));

  // R4: disabled limiting drops the flag
  a_r4_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !limitEn |=> !limitHit);

  // R7: flag sticky within a field
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (limitHit && limitEn && !fieldStart && $stable(maxCount)) |=> limitHit);

  // R10: counter saturates
  a_r10_nowrap: assert property (@(posedge clk) disable iff (!rstN)
    (wordCount == CNT_TOP && !fieldStart) |=> (wordCount == CNT_TOP));
endmodule

// File: rtl/fsl_sample_path.sv
module fsl_sample_path
  import fsl_pkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  gateCtl_t            gateCtl,
  input  logic [SAMPLE_W-1:0] sampleIn,
  output logic [SAMPLE_W-1:0] sampleOut,
  output logic                sampleOutValid
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleOut      <= '0;
      sampleOutValid <= 1'b0;
    end else begin
      sampleOutValid <= gateCtl.take;
      if (gateCtl.take) begin
        sampleOut <= gateCtl.zeroSample ? '0 : sampleIn;
      end
    end
  end

  // R5: gated samples leave as zero
  a_r5_zero: assert property (@(posedge clk) disable iff (!rstN)
    (gateCtl.take && gateCtl.zeroSample) |=> (sampleOut == '0));

  // R8: ungated samples pass unchanged
  a_r8_pass: assert property (@(posedge clk) disable iff (!rstN)
    (gateCtl.take && !gateCtl.zeroSample) |=> (sampleOut == $past(sampleIn)));

  // R8: output holds without a sample
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    !gateCtl.take |=> ($stable(sampleOut) && !sampleOutValid));
endmodule

// File: rtl/field_size_limiter.sv
module field_size_limiter
  import fsl_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int MAX_W    = 16,
  parameter int MODE_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                fieldStart,
  input  logic                wordStrobe,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic [MODE_W-1:0]   modeReg,
  input  logic [MAX_W-1:0]    maxCount,
  output logic [SAMPLE_W-1:0] sampleOut,
  output logic                sampleOutValid,
  output logic                limitHit
);
  gateCtl_t gateCtl;

  fsl_limit_ctrl #(
    .MAX_W(MAX_W), .STEP_BITS(4), .MODE_W(MODE_W), .ENABLE_BIT(4)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .fieldStart(fieldStart), .wordStrobe(wordStrobe),
    .sampleValid(sampleValid), .modeReg(modeReg), .maxCount(maxCount),
    .gateCtl(gateCtl), .limitHit(limitHit)
  );

  fsl_sample_path #(.SAMPLE_W(SAMPLE_W)) u_path (
    .clk(clk), .rstN(rstN), .gateCtl(gateCtl), .sampleIn(sampleIn),
    .sampleOut(sampleOut), .sampleOutValid(sampleOutValid)
  );
endmodule

// File: tb/field_size_limiter_tb.sv
module field_size_limiter_tb;
  localparam int SW = 12;
  localparam int MW = 8;
  localparam int CW = MW + 4;
  localparam int CTOP = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fieldStart = 1'b0, wordStrobe = 1'b0, sampleValid = 1'b0;
  logic [SW-1:0] sampleIn = '0;
  logic [7:0] modeReg = 8'h10;
  logic [MW-1:0] maxCount = '0;
  logic [SW-1:0] sampleOut;
  logic sampleOutValid, limitHit;

  int checks = 0, errors = 0, cycles = 0;
  int mCount = 0;
  bit mFlag = 0, mValid = 0;
  logic [SW-1:0] mOut = '0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  field_size_limiter #(.SAMPLE_W(SW), .MAX_W(MW), .MODE_W(8)) u_dut (
    .clk(clk), .rstN(rstN), .fieldStart(fieldStart), .wordStrobe(wordStrobe),
    .sampleValid(sampleValid), .sampleIn(sampleIn), .modeReg(modeReg),
    .maxCount(maxCount), .sampleOut(sampleOut),
    .sampleOutValid(sampleOutValid), .limitHit(limitHit)
  );

  function automatic int nextCnt(int c, bit fs, bit ws);
    if (fs) return ws ? 1 : 0;
    if (ws && c < CTOP) return c + 1;
    return c;
  endfunction

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic cycle(bit fs, bit ws, bit sv, logic [SW-1:0] s);
    fieldStart = fs; wordStrobe = ws; sampleValid = sv; sampleIn = s;
    @(posedge clk);
    if (sv) mOut = (mFlag && !fs) ? '0 : s;
    mValid = sv;
    mCount = nextCnt(mCount, fs, ws);
    mFlag = modeReg[4] && (mCount >= (int'(maxCount) << 4));
    #1;
    check("limitHit", int'(limitHit), int'(mFlag));
    check("sampleOutValid", int'(sampleOutValid), int'(mValid));
    check("sampleOut", int'(sampleOut), int'(mOut));
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    tag = "R1";
    check("limitHit", int'(limitHit), 0);
    check("sampleOutValid", int'(sampleOutValid), 0);
    check("sampleOut", int'(sampleOut), 0);
    rstN = 1'b1;

    // R2 R5: limit 32 words, sample in the reaching cycle still passes
    tag = "R2"; maxCount = 8'd2; modeReg = 8'h10;
    cycle(1, 0, 1, 12'h123);
    for (int i = 0; i < 31; i++) cycle(0, 1, 1, SW'(i + 1));
    check("flag before limit", int'(limitHit), 0);
    cycle(0, 1, 1, 12'h7AB);
    check("flag at limit", int'(limitHit), 1);
    check("reaching sample", int'(sampleOut), 12'h7AB);
    tag = "R5";
    cycle(0, 0, 1, 12'h555);
    check("zeroed sample", int'(sampleOut), 0);
    tag = "R7";
    for (int i = 0; i < 5; i++) cycle(0, i[0], 1, 12'hFFF);
    check("sticky flag", int'(limitHit), 1);

    // R6: start with word and sample in same cycle
    tag = "R6";
    cycle(1, 1, 1, 12'h3C3);
    check("start-cycle sample", int'(sampleOut), 12'h3C3);
    check("flag cleared", int'(limitHit), 0);
    for (int i = 0; i < 31; i++) cycle(0, 1, 0, '0);
    check("flag after 32 words incl start", int'(limitHit), 1);

    // R9: zero limit
    tag = "R9"; maxCount = '0;
    cycle(1, 0, 1, 12'h0AA);
    check("start sample", int'(sampleOut), 12'h0AA);
    cycle(0, 0, 1, 12'h0BB);
    check("zero-limit sample", int'(sampleOut), 0);

    // R4 R3: disabled, other mode bits set
    tag = "R4"; modeReg = 8'hEF;
    cycle(0, 1, 1, 12'h321);
    check("disabled flag", int'(limitHit), 0);
    cycle(0, 1, 1, 12'h456);
    check("disabled pass", int'(sampleOut), 12'h456);
    tag = "R3"; modeReg = 8'h10;
    cycle(0, 0, 1, 12'h111);
    check("bit4 only enables", int'(limitHit), 1);

    // R10: saturation with max all ones
    tag = "R10"; maxCount = 8'hFF;
    cycle(1, 0, 0, '0);
    for (int i = 0; i < 4300; i++) cycle(0, 1, 0, '0);
    check("saturated flag", int'(limitHit), 1);

    // R8 and mixed: random fields
    tag = "R8";
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 199) == 0) maxCount = MW'($urandom_range(0, 6));
      if ($urandom_range(0, 299) == 0)
        modeReg = ($urandom_range(0, 3) == 0) ? 8'h00 : (8'($urandom) | 8'h10);
      cycle($urandom_range(0, 79) == 0, $urandom_range(0, 2) != 0,
            $urandom_range(0, 1) == 1, SW'($urandom));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule